// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the processor-facing side of a two-channel serial communications controller. A host reaches it through a two-bit address, an eight-bit write bus, read and write strobes and an eight-bit registered read bus. Each channel owns sixteen write registers and sixteen read registers. These are not mapped directly. A control write first loads a per-channel register pointer. The next control access then uses the register that the pointer names, and the pointer falls back to zero afterwards.

On the character side, each channel sees a byte source (`rx_avail`, `rx_data`, `rx_pop`) and a byte sink (`tx_valid`, `tx_data`). Interrupt state for both channels lives in one shared pending register. That register is readable as read register 3 of channel A and drives a single interrupt line. The line is gated by a master enable held in channel A.

Top module: `dsc_reg_front`

## Requirements
- R1: `addr[0]` selects the port (0 = control, 1 = data). `addr[1]` selects the channel (1 = channel A, 0 = channel B). Per-channel vectors use index 0 for B and index 1 for A.
- R2: Each channel's 4-bit pointer is 0 after reset. A control write while the pointer is 0 loads the pointer from `wdata[3:0]` and ignores the upper bits.
- R3: A control write while the pointer is nonzero stores the byte in that write register and returns the pointer to 0. The next control read therefore yields read register 0.
- R4: A control read puts the read register selected by the pointer on `rdata` in the cycle after the strobe edge, then returns the pointer to 0. Read register 3 of channel A is the pending register. Read register 3 of channel B and all unused read registers read 0.
- R5: In read register 0 of either channel, bits 2, 3 and 5 (transmit ready, carrier detect, clear to send) always read 1. Bit 0 is receive ready.
- R6: A data read returns the channel's `rx_data` byte, or 0 when `rx_avail` is low. It pulses that channel's `rx_pop` during the strobe and clears the receive-ready bit on the strobe edge.
- R7: A data write with a nonzero byte gives a one-cycle `tx_valid` pulse for that channel with `tx_data` equal to the byte, in the cycle after the strobe edge. A zero byte gives no pulse. In both cases the write sets the channel's transmit-pending bit (bit 0 for B, bit 3 for A).
- R8: On every clock edge, each channel's receive-pending bit (bit 1 for B, bit 4 for A) and its receive-ready bit are loaded from its `rx_avail`. This is skipped, and the pending bit forced to 0, while a transmit interrupt is being asserted.
- R9: `irq` is high when write register 9 bit 3 of channel A (master enable) is set and at least one of these holds: some channel has its transmit-pending bit set together with write register 1 bit 1; or some channel has its receive-pending bit set and write register 1 bits 4:3 are not 00.
- R10: Writing 0x38 to write register 8 of either channel clears the whole pending register. Any other value written there does not clear it.
- R11: During and right after reset, `rdata` is 0, `irq` is low and no `tx_valid` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Bit 0 control/data, bit 1 channel |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| rx_avail | input | 2 | Received byte present, per channel |
| rx_data | input | 16 | Received bytes, channel B in [7:0] |
| rx_pop | output | 2 | Byte consumed, per channel |
| tx_valid | output | 2 | Transmit byte strobe, per channel |
| tx_data | output | 8 | Transmit byte |

## Verification
On every cycle, the assertions check the pointer sequencing (load, return to zero after a store or read), the transmit echo and zero-byte drop, the effect of the clear command on the transmit-pending bits, and the quiet state after reset. The interrupt gating comes from a combination of enables, pending bits and the receive suppression while a transmit interrupt is live. Only the bench sweep can show it: the sweep walks every master, transmit-enable, receive-mode, transmit and receive combination on both channels and reads the pending register back. The bench scenarios also cover read-data contents, the empty-receiver zero, and the registers that read 0.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int RR0_RXRDY = 0;
  localparam int RR0_TXRDY = 2;
  localparam int RR0_DCD   = 3;
  localparam int RR0_CTS   = 5;
  localparam int WR1_TIE   = 1;
  localparam int WR1_RIE_L = 3;
  localparam int WR9_MIE   = 3;
  localparam int IDX_STAT  = 0;
  localparam int IDX_PEND  = 3;
  localparam int IDX_MODE  = 1;
  localparam int IDX_CMD   = 8;
  localparam int IDX_MAST  = 9;
  localparam logic [7:0] CLR_CODE = 8'h38;

  typedef struct packed {
    logic ctl_wr;
    logic ctl_rd;
    logic dat_wr;
    logic dat_rd;
  } acc_t;

  function automatic int tx_bit(input int ch);
    return ch * 3;
  endfunction

  function automatic int rx_bit(input int ch);
    return ch * 3 + 1;
  endfunction
endpackage

// File: rtl/dsc_acc_decode.sv
module dsc_acc_decode
  import dsc_pkg::*;
#(
  parameter int CH = 2
) (
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  output acc_t       acc [CH]
);
  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic hit;
    assign hit = (addr[1] == c[0]);
    always_comb begin
      acc[c].ctl_wr = hit & wr_en & ~addr[0];
      acc[c].ctl_rd = hit & rd_en & ~addr[0];
      acc[c].dat_wr = hit & wr_en &  addr[0];
      acc[c].dat_rd = hit & rd_en &  addr[0];
    end
  end
endmodule

// File: rtl/dsc_chan_regs.sv
module dsc_chan_regs
  import dsc_pkg::*;
#(
  parameter int DW       = 8,
  parameter int REG_CNT  = 16,
  parameter bit SHOW_PND = 1'b0,
  parameter bit OWN_MIE  = 1'b0,
  localparam int PTR_W   = $clog2(REG_CNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  acc_t             acc,
  input  logic [DW-1:0]    wdata,
  input  logic             rx_seen,
  input  logic [DW-1:0]    pend,
  output logic [PTR_W-1:0] ptr,
  output logic [DW-1:0]    ctl_rdata,
  output logic             tie,
  output logic             rie_on,
  output logic             mie,
  output logic             clr_req
);
  localparam logic [PTR_W-1:0] P_STAT = PTR_W'(IDX_STAT);
  localparam logic [PTR_W-1:0] P_PEND = PTR_W'(IDX_PEND);
  localparam logic [PTR_W-1:0] P_CMD  = PTR_W'(IDX_CMD);
  localparam logic [DW-1:0] RR0_FIXED =
    DW'((1 << RR0_TXRDY) | (1 << RR0_DCD) | (1 << RR0_CTS));

  logic [DW-1:0]    wreg [REG_CNT];
  logic [PTR_W-1:0] ptr_q;
  logic             rx_rdy_q;

  assign ptr = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      for (int i = 0; i < REG_CNT; i++) wreg[i] <= '0;
    end else if (acc.ctl_wr) begin
      if (ptr_q == P_STAT) begin
        ptr_q <= wdata[PTR_W-1:0];
      end else begin
        wreg[ptr_q] <= wdata;
        ptr_q       <= '0;
      end
    end else if (acc.ctl_rd) begin
      ptr_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             rx_rdy_q <= 1'b0;
    else if (acc.dat_rd) rx_rdy_q <= 1'b0;
    else if (rx_seen)    rx_rdy_q <= 1'b1;
  end

  always_comb begin
    ctl_rdata = '0;
    if (ptr_q == P_STAT) begin
      ctl_rdata = RR0_FIXED;
      ctl_rdata[RR0_RXRDY] = rx_rdy_q;
    end else if (ptr_q == P_PEND && SHOW_PND) begin
      ctl_rdata = pend;
    end
  end

  assign tie     = wreg[IDX_MODE][WR1_TIE];
  assign rie_on  = |wreg[IDX_MODE][WR1_RIE_L +: 2];
  assign mie     = OWN_MIE ? wreg[IDX_MAST][WR9_MIE] : 1'b0;
  assign clr_req = acc.ctl_wr && (ptr_q == P_CMD) && (wdata == DW'(CLR_CODE));
endmodule

// File: rtl/dsc_irq_ctrl.sv
module dsc_irq_ctrl
  import dsc_pkg::*;
#(
  parameter int DW = 8,
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] set_tx,
  input  logic [CH-1:0] rx_avail,
  input  logic          clr,
  input  logic [CH-1:0] tie,
  input  logic [CH-1:0] rie_on,
  input  logic          mie,
  output logic [DW-1:0] pend,
  output logic [CH-1:0] rx_seen,
  output logic          irq
);
  logic [DW-1:0] pend_q;
  logic [CH-1:0] tx_on, rx_on;
  logic          tx_assert;

  for (genvar c = 0; c < CH; c++) begin : g_src
    assign tx_on[c] = pend_q[tx_bit(c)] & tie[c];
    assign rx_on[c] = pend_q[rx_bit(c)] & rie_on[c];
  end

  assign tx_assert = |tx_on;
  assign rx_seen   = rx_avail & {CH{~tx_assert}};
  assign irq       = mie & (tx_assert | (|rx_on));
  assign pend      = pend_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pend_q <= '0;
    end else begin
      for (int c = 0; c < CH; c++) begin
        pend_q[tx_bit(c)] <= pend_q[tx_bit(c)] | set_tx[c];
        pend_q[rx_bit(c)] <= rx_seen[c];
      end
    end
  end
endmodule

// File: rtl/dsc_reg_front.sv
module dsc_reg_front
  import dsc_pkg::*;
#(
  parameter int DW      = 8,
  parameter int REG_CNT = 16,
  localparam int CH     = 2,
  localparam int PTR_W  = $clog2(REG_CNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq,
  input  logic [CH-1:0]    rx_avail,
  input  logic [CH*DW-1:0] rx_data,
  output logic [CH-1:0]    rx_pop,
  output logic [CH-1:0]    tx_valid,
  output logic [DW-1:0]    tx_data
);
  acc_t          acc [CH];
  logic [DW-1:0] ctl_rd_v [CH];
  logic [CH-1:0] tie_v, rie_v, mie_v, clr_v, set_tx, rx_seen;
  logic [PTR_W-1:0] ptr_b, ptr_a;
  logic [PTR_W-1:0] ptr_v [CH];
  logic [DW-1:0] pend;
  logic          chn;

  assign chn = addr[1];

  dsc_acc_decode #(.CH(CH)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .acc(acc)
  );

  for (genvar c = 0; c < CH; c++) begin : g_chan
    dsc_chan_regs #(
      .DW(DW), .REG_CNT(REG_CNT),
      .SHOW_PND(c == 1), .OWN_MIE(c == 1)
    ) u_regs (
      .clk(clk), .rst(rst), .acc(acc[c]), .wdata(wdata),
      .rx_seen(rx_seen[c]), .pend(pend), .ptr(ptr_v[c]),
      .ctl_rdata(ctl_rd_v[c]), .tie(tie_v[c]), .rie_on(rie_v[c]),
      .mie(mie_v[c]), .clr_req(clr_v[c])
    );
    assign set_tx[c] = acc[c].dat_wr;
    assign rx_pop[c] = acc[c].dat_rd;
  end

  assign ptr_b = ptr_v[0];
  assign ptr_a = ptr_v[1];

  dsc_irq_ctrl #(.DW(DW), .CH(CH)) u_irq (
    .clk(clk), .rst(rst), .set_tx(set_tx), .rx_avail(rx_avail),
    .clr(|clr_v), .tie(tie_v), .rie_on(rie_v), .mie(|mie_v),
    .pend(pend), .rx_seen(rx_seen), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      tx_valid <= '0;
      tx_data  <= '0;
    end else begin
      tx_valid <= '0;
      if (rd_en) begin
        if (!addr[0])           rdata <= ctl_rd_v[chn];
        else if (rx_avail[chn]) rdata <= rx_data[chn*DW +: DW];
        else                    rdata <= '0;
      end
      if (wr_en && addr[0] && (wdata != '0)) begin
        tx_valid[chn] <= 1'b1;
        tx_data       <= wdata;
      end
    end
  end
endmodule

// File: rtl/dsc_reg_front_chk.sv
module dsc_reg_front_chk
  import dsc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [DW-1:0]    wdata,
  input logic             irq,
  input logic [1:0]       tx_valid,
  input logic [DW-1:0]    tx_data,
  input logic [PTR_W-1:0] ptr_b,
  input logic [PTR_W-1:0] ptr_a,
  input logic [DW-1:0]    pend
);
  a_r2_ptr_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr[0] && addr[1] && ptr_a == '0)
      |=> (ptr_a == $past(wdata[PTR_W-1:0])));

  a_r3_ptr_back_after_store: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr[0] && addr[1] && ptr_a != '0) |=> (ptr_a == '0));

  a_r4_ptr_back_after_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr[0] && !addr[1]) |=> (ptr_b == '0));

  a_r7_tx_echo: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[0] && wdata != '0)
      |=> (tx_valid[$past(addr[1])] && $onehot0(tx_valid) && tx_data == $past(wdata)));

  a_r7_zero_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[0] && wdata == '0) |=> (tx_valid == '0));

  a_r10_clear_tx: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr[0] && ((addr[1] ? ptr_a : ptr_b) == PTR_W'(IDX_CMD))
      && wdata == DW'(CLR_CODE))
      |=> (!pend[tx_bit(0)] && !pend[tx_bit(1)]));

  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && tx_valid == '0));
endmodule

bind dsc_reg_front dsc_reg_front_chk #(.DW(DW), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data),
  .ptr_b(ptr_b), .ptr_a(ptr_a), .pend(pend)
);

// File: tb/tb_dsc_reg_front.sv
module tb_dsc_reg_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic [1:0]  rx_avail = '0;
  logic [15:0] rx_data = '0;
  logic [1:0]  rx_pop, tx_valid;
  logic [7:0]  tx_data;
  logic [1:0]  pop_s;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dsc_reg_front dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rx_avail(rx_avail),
    .rx_data(rx_data), .rx_pop(rx_pop), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_en = w; rd_en = r; wdata = d;
    #1 pop_s = rx_pop;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic ctl_wr(input logic ch, input int idx, input logic [7:0] v);
    op(1, 0, {ch, 1'b0}, 8'(idx));
    op(1, 0, {ch, 1'b0}, v);
  endtask

  task automatic ctl_rd(input logic ch, input int idx);
    if (idx != 0) op(1, 0, {ch, 1'b0}, 8'(idx));
    op(0, 1, {ch, 1'b0}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 rdata in reset", rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 irq after reset", irq, 0);
    chk("R11 tx_valid after reset", tx_valid, 0);

    // R5 / R4: status register, both channels, no receive data
    ctl_rd(1'b0, 0); chk("R5 RR0 chan B", rdata, 8'h2C);
    ctl_rd(1'b1, 0); chk("R5 RR0 chan A", rdata, 8'h2C);
    // R4: unused registers and channel B register 3 read zero
    ctl_rd(1'b1, 5); chk("R4 unused RR5", rdata, 0);
    ctl_rd(1'b0, 3); chk("R4 RR3 chan B", rdata, 0);
    // R2: pointer loaded from low nibble only
    op(1, 0, 2'b10, 8'hF3); op(0, 1, 2'b10, 0);
    chk("R2 high bits ignored, RR3 A", rdata, 0);
    // R4: pointer back to zero after a read
    op(0, 1, 2'b10, 0); chk("R4 next read is RR0", rdata, 8'h2C);

    // R6 / R8: receive path on channel A
    rx_data = 16'h5A00; rx_avail = 2'b10;
    @(negedge clk);
    ctl_rd(1'b1, 0); chk("R8 receive ready set", rdata, 8'h2D);
    op(0, 1, 2'b11, 0);
    chk("R6 data read byte", rdata, 8'h5A);
    chk("R6 pop pulse", pop_s, 2'b10);
    rx_avail = 2'b00;
    ctl_rd(1'b1, 0); chk("R6 receive ready cleared", rdata, 8'h2C);
    op(0, 1, 2'b01, 0); chk("R6 empty read is zero", rdata, 0);
    chk("R1 pop on channel B", pop_s, 2'b01);

    // R7 / R1: transmit path
    op(1, 0, 2'b11, 8'hC3);
    chk("R7 tx strobe A", tx_valid, 2'b10);
    chk("R7 tx byte", tx_data, 8'hC3);
    op(1, 0, 2'b01, 8'h00);
    chk("R7 zero byte dropped", tx_valid, 0);
    ctl_rd(1'b1, 3); chk("R7 both tx pending bits", rdata, 8'h09);
    // R10: wrong code does not clear, correct code on B clears
    ctl_wr(1'b1, 8, 8'h30);
    ctl_rd(1'b1, 3); chk("R10 other code keeps pending", rdata, 8'h09);
    ctl_wr(1'b0, 8, 8'h38);
    ctl_rd(1'b1, 3); chk("R10 clear via channel B", rdata, 0);
    // R3: pointer returns to zero after a store
    ctl_wr(1'b0, 2, 8'h77);
    op(0, 1, 2'b00, 0); chk("R3 read after store is RR0", rdata, 8'h2C);

    // R8 / R9 sweep over both channels and all gating combinations
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 64; k++) begin
        int m, tie, rie, tx, rx, txa, rxp, ex_irq, ex_pend;
        m = k[0]; tie = k[1]; rie = k[3:2]; tx = k[4]; rx = k[5];
        rx_avail = 2'b00;
        ctl_wr(1'(ch), 8, 8'h38);
        ctl_wr(1'(ch), 1, 8'((tie << 1) | (rie << 3)));
        ctl_wr(1'b1, 9, 8'(m << 3));
        rx_avail[ch] = 1'(rx);
        if (tx != 0) begin
          op(1, 0, {1'(ch), 1'b1}, 8'h41);
          chk("R7 sweep tx strobe", tx_valid, 1 << ch);
        end
        @(negedge clk);
        txa = tx & tie;
        rxp = rx & (txa == 0 ? 1 : 0);
        ex_irq = m & (txa | (rxp & (rie != 0 ? 1 : 0)));
        ex_pend = (tx << (ch * 3)) | (rxp << (ch * 3 + 1));
        chk("R9 irq gating", irq, ex_irq);
        ctl_rd(1'b1, 3);
        chk("R8 pending readback", rdata, ex_pend);
      end
    end
    rx_avail = 2'b00;
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule